// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a single-clock synchronous static memory. Address, write data, the three chip-select inputs, the two address-load strobes, the advance input and every write control are captured on the rising clock edge. Read data is not pipelined: the word at the address held in the address register appears on the data output during the cycle that follows the loading edge. The two least significant address bits come from a two-bit beat counter, so one load can be followed by up to three further beats inside an aligned group of four words. The counter runs in linear order or in XOR-interleaved order, chosen by a static mode input.

Writes are self-timed. The controls and data captured at one edge are committed to the array at the next edge, at the address that was current between the two edges. A global write enable stores the whole word. A byte write enable stores only the selected byte lanes. The output-enable and sleep inputs act without waiting for a clock. The shared data bus is modelled as a data output together with a drive-enable flag, and a board-level tri-state buffer would use that flag.

This is a memory port with plain control pins. It has no valid/ready handshake and no back-pressure: every captured cycle is accepted, and read data is valid exactly while the drive-enable flag is high.

Top module: `fsb_sram`

## Requirements
- R1: While reset is low, and after reset until the first address load that finds the chip selected, the drive-enable output dq_oe_o is 0 and dq_o is 0.
- R2: An edge where adsc_n_i is 0, adsp_n_i is 1 and the chip is selected loads addr_i and captures the write controls and din_i. The write commits at the following edge, so a later read of that address returns the written data.
- R3: An edge where adsp_n_i is 0 loads addr_i as a read. All write controls at that edge are ignored, and this also holds when adsc_n_i is 0 at the same edge.
- R4: The chip is selected only when ce1_n_i=0, ce2_i=1 and ce3_n_i=0 at a loading edge. A load without selection drives nothing, stores nothing, and keeps the bus quiet until the next selected load.
- R5: With lbo_n_i=0 (linear), beat n after a load at start offset s uses low address bits (s+n) mod 4. The upper address bits stay unchanged and the sequence wraps back to s after four advances.
- R6: With lbo_n_i=1 (interleaved), beat n uses low address bits s XOR n.
- R7: An edge with both strobes at 1 and adv_n_i=1 holds the current address. An edge with adv_n_i=0 and no strobe advances the beat by one.
- R8: gw_n_i=0 writes all bytes of the word whatever bwe_n_i and bsel_n_i are.
- R9: With gw_n_i=1 and bwe_n_i=0, only byte lanes whose bsel_n_i bit is 0 are written (bit b guards data bits 8b+7..8b). With both at 1 the cycle is a read.
- R10: Read data for the address loaded at an edge is on dq_o with dq_oe_o=1 in the cycle right after that edge, and a new address can be loaded on every edge.
- R11: dq_oe_o is 0 whenever oe_n_i=1 or sleep_i=1, with no clock edge needed, and during the cycle after an edge that captured a write.
- R12: Edges with sleep_i=1 change no address, selection or stored word. After sleep_i returns to 0, the previous address is read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr_i | input | ADDR_W | Word address, captured at a load |
| din_i | input | NBYTES*BYTE_W | Write data |
| ce1_n_i | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| ce3_n_i | input | 1 | Chip select, active low |
| adsp_n_i | input | 1 | Read-only address load strobe, active low, takes priority |
| adsc_n_i | input | 1 | Address load strobe allowing write, active low |
| adv_n_i | input | 1 | Beat advance, active low |
| gw_n_i | input | 1 | Whole-word write, active low |
| bwe_n_i | input | 1 | Byte write enable, active low |
| bsel_n_i | input | NBYTES | Per-lane byte selects, active low |
| lbo_n_i | input | 1 | Burst order: 0 linear, 1 interleaved (tie high by default) |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Low-power hold, active high, asynchronous gating |
| dq_o | output | NBYTES*BYTE_W | Read data, zero when not driving |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The assertions assume that lbo_n_i does not change during a burst. The linear-step and hold properties say nothing about an edge where the order input moves. They also assume that every input is settled and free of X at each edge once reset has been released. The bench meets both conditions: it drives all inputs a quarter period after the rising edge, only ever changes the burst order just before a fresh load, and reads back only addresses it has written, because the array has no reset value.

// File: rtl/fsb_pkg.sv
`timescale 1ns/1ps
package fsb_pkg;
  // Low address bits for a beat: linear adds, interleaved XORs.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       linear);
    return linear ? (start + beat) : (start ^ beat);
  endfunction
endpackage

// File: rtl/fsb_addr_seq.sv
`timescale 1ns/1ps
module fsb_addr_seq
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              load_i,
  input  logic              ce_ok_i,
  input  logic              adv_i,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic              sel_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic              sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      sel_q  <= 1'b0;
    end else if (!sleep_i) begin
      if (load_i) begin
        base_q <= addr_i;
        beat_q <= '0;
        sel_q  <= ce_ok_i;
      end else if (adv_i) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign eff_addr_o = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], beat_q, linear_i)};
  assign sel_o      = sel_q;

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && load_i) |=> (eff_addr_o == $past(addr_i)));
  // R5
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !load_i && adv_i && linear_i) |=>
      (!linear_i || eff_addr_o[1:0] == $past(eff_addr_o[1:0]) + 2'd1));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !load_i && !adv_i) |=>
      ($stable(eff_addr_o) || linear_i != $past(linear_i)));
  // R12
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(base_q) && $stable(beat_q) && $stable(sel_q)));
endmodule

// File: rtl/fsb_wr_decode.sv
`timescale 1ns/1ps
module fsb_wr_decode #(
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [NBYTES-1:0] bsel_n_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [NBYTES-1:0] mask_q,
  output logic [DATA_W-1:0] data_q
);
  logic [NBYTES-1:0] mask_d;

  always_comb begin
    if (!allow_i)      mask_d = '0;
    else if (!gw_n_i)  mask_d = '1;
    else if (!bwe_n_i) mask_d = ~bsel_n_i;
    else               mask_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      data_q <= '0;
    end else begin
      mask_q <= mask_d;
      data_q <= din_i;
    end
  end

  // R8
  gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_i && !gw_n_i) |=> (&mask_q));
endmodule

// File: rtl/fsb_array.sv
`timescale 1ns/1ps
module fsb_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NBYTES-1:0] mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBYTES; b++) begin
      if (mask_i[b]) mem[addr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/fsb_sram.sv
`timescale 1ns/1ps
module fsb_sram #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ce1_n_i,
  input  logic              ce2_i,
  input  logic              ce3_n_i,
  input  logic              adsp_n_i,
  input  logic              adsc_n_i,
  input  logic              adv_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [NBYTES-1:0] bsel_n_i,
  input  logic              lbo_n_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              strobe, ce_ok, adv, wr_allow, sel_q;
  logic [ADDR_W-1:0] eff_addr;
  logic [NBYTES-1:0] wmask;
  logic [DATA_W-1:0] wdata, rdata;

  assign strobe   = !adsp_n_i || !adsc_n_i;
  assign ce_ok    = !ce1_n_i && ce2_i && !ce3_n_i;
  assign adv      = !strobe && !adv_n_i;
  // A read-strobe load never writes; otherwise writes follow the selection.
  assign wr_allow = !sleep_i && (strobe ? (adsp_n_i && ce_ok) : sel_q);

  fsb_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .load_i(strobe),
    .ce_ok_i(ce_ok), .adv_i(adv), .linear_i(!lbo_n_i), .addr_i(addr_i),
    .eff_addr_o(eff_addr), .sel_o(sel_q)
  );

  fsb_wr_decode #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_wdec (
    .clk(clk), .rst_n(rst_n), .allow_i(wr_allow), .gw_n_i(gw_n_i),
    .bwe_n_i(bwe_n_i), .bsel_n_i(bsel_n_i), .din_i(din_i),
    .mask_q(wmask), .data_q(wdata)
  );

  fsb_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .addr_i(eff_addr), .mask_i(wmask), .wdata_i(wdata),
    .rdata_o(rdata)
  );

  assign dq_oe_o = sel_q && !oe_n_i && !sleep_i && (wmask == '0);
  assign dq_o    = dq_oe_o ? rdata : '0;

  // R4
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && strobe && !ce_ok) |=> !dq_oe_o);
  // R3
  adsp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !adsp_n_i) |=> (wmask == '0));
endmodule

// File: tb/tb_fsb_sram.sv
`timescale 1ns/1ps
module tb_fsb_sram;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, lbo_n, oe_n, sleep;
  logic [NB-1:0] bsel_n;
  logic [DW-1:0] dq;
  logic dq_oe;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fsb_sram dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .din_i(din), .ce1_n_i(ce1_n),
    .ce2_i(ce2), .ce3_n_i(ce3_n), .adsp_n_i(adsp_n), .adsc_n_i(adsc_n),
    .adv_n_i(adv_n), .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bsel_n_i(bsel_n),
    .lbo_n_i(lbo_n), .oe_n_i(oe_n), .sleep_i(sleep), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  // {is_write, pad, addr[5:0], data[15:0]}
  localparam logic [23:0] VEC [12] = '{
    24'h831234, 24'h845678, 24'hBFABCD, 24'h800F0F,
    24'h031234, 24'h3FABCD, 24'h90AAAA, 24'h045678,
    24'h000F0F, 24'h10AAAA, 24'h831111, 24'h031111
  };

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = '1;
    ce1_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0; sleep = 0; din = '0;
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle(); adsc_n = 0; gw_n = 0; addr = a; din = d; tick();
  endtask

  task automatic rd(input logic [AW-1:0] a);
    idle(); adsp_n = 0; addr = a; tick();
  endtask

  task automatic step_adv();
    idle(); adv_n = 0; tick();
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    idle(); addr = '0; lbo_n = 1;
    repeat (3) @(posedge clk);
    #5;
    check("R1 bus quiet in reset", {dq_oe, dq}, 17'h0);
    rst_n = 1;
    tick();
    check("R1 deselected after reset", {dq_oe, dq}, 17'h0);

    // R2 / R10: table walk, writes via load-with-write, reads back to back
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][23]) begin
        wr(VEC[i][21:16], VEC[i][15:0]);
        check("R2 R11 bus off in write cycle", {dq_oe, dq}, 17'h0);
      end else begin
        rd(VEC[i][21:16]);
        check("R10 flow-through read", {dq_oe, dq}, {1'b1, VEC[i][15:0]});
      end
    end

    // R3: read strobe ignores write controls, also when both strobes low
    idle(); adsp_n = 0; gw_n = 0; addr = 6'h04; din = 16'hDEAD; tick();
    check("R3 read-strobe load reads", {dq_oe, dq}, {1'b1, 16'h5678});
    rd(6'h04);
    check("R3 no write on read strobe", {dq_oe, dq}, {1'b1, 16'h5678});
    idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 6'h00; din = 16'hBEEF; tick();
    check("R3 read strobe has priority", {dq_oe, dq}, {1'b1, 16'h0F0F});
    rd(6'h00);
    check("R3 priority stored nothing", {dq_oe, dq}, {1'b1, 16'h0F0F});

    // R4: deselected loads
    idle(); adsc_n = 0; ce2 = 0; gw_n = 0; addr = 6'h3F; din = 16'h0000; tick();
    check("R4 deselected load quiet", {dq_oe, dq}, 17'h0);
    idle(); tick();
    check("R4 stays deselected", {dq_oe, dq}, 17'h0);
    idle(); adsp_n = 0; ce1_n = 1; addr = 6'h3F; tick();
    check("R4 ce1 high deselects", {dq_oe, dq}, 17'h0);
    rd(6'h3F);
    check("R4 deselected write ignored", {dq_oe, dq}, {1'b1, 16'hABCD});

    // R8: global write beats byte controls
    idle(); adsc_n = 0; gw_n = 0; bwe_n = 0; bsel_n = 2'b10; addr = 6'h10; din = 16'h5555; tick();
    rd(6'h10);
    check("R8 global write all bytes", {dq_oe, dq}, {1'b1, 16'h5555});

    // R9: byte lanes
    idle(); adsc_n = 0; bwe_n = 0; bsel_n = 2'b10; addr = 6'h03; din = 16'hABCD; tick();
    rd(6'h03);
    check("R9 lane 0 only", {dq_oe, dq}, {1'b1, 16'h11CD});
    idle(); adsc_n = 0; bwe_n = 0; bsel_n = 2'b01; addr = 6'h03; din = 16'h9900; tick();
    rd(6'h03);
    check("R9 lane 1 only", {dq_oe, dq}, {1'b1, 16'h99CD});
    idle(); adsc_n = 0; addr = 6'h03; din = 16'h0000; tick();
    check("R9 no enables reads", {dq_oe, dq}, {1'b1, 16'h99CD});

    // R5: linear write burst fills 08..0B, then linear read from 09
    lbo_n = 0;
    wr(6'h08, 16'h0800);
    for (int k = 1; k < 4; k++) begin
      idle(); adv_n = 0; gw_n = 0; din = 16'h0800 + 16'(k); tick();
    end
    idle(); tick();
    rd(6'h09);
    check("R5 linear beat0", {dq_oe, dq}, {1'b1, 16'h0801});
    step_adv(); check("R5 linear beat1", {dq_oe, dq}, {1'b1, 16'h0802});
    step_adv(); check("R5 linear beat2", {dq_oe, dq}, {1'b1, 16'h0803});
    step_adv(); check("R5 linear beat3 wraps", {dq_oe, dq}, {1'b1, 16'h0800});
    step_adv(); check("R5 linear back to start", {dq_oe, dq}, {1'b1, 16'h0801});

    // R6: interleaved order
    lbo_n = 1;
    rd(6'h0A);
    check("R6 interleaved beat0", {dq_oe, dq}, {1'b1, 16'h0802});
    step_adv(); check("R6 interleaved beat1", {dq_oe, dq}, {1'b1, 16'h0803});
    step_adv(); check("R6 interleaved beat2", {dq_oe, dq}, {1'b1, 16'h0800});
    step_adv(); check("R6 interleaved beat3", {dq_oe, dq}, {1'b1, 16'h0801});
    rd(6'h09);
    step_adv(); check("R6 interleaved 09 beat1", {dq_oe, dq}, {1'b1, 16'h0800});
    step_adv(); check("R6 interleaved 09 beat2", {dq_oe, dq}, {1'b1, 16'h0803});

    // R7: hold without advance
    lbo_n = 0;
    rd(6'h0B);
    idle(); tick();
    check("R7 hold", {dq_oe, dq}, {1'b1, 16'h0803});
    idle(); tick();
    check("R7 hold again", {dq_oe, dq}, {1'b1, 16'h0803});
    step_adv(); check("R7 advance after hold", {dq_oe, dq}, {1'b1, 16'h0800});

    // R11: asynchronous output enable and sleep gating
    rd(6'h04);
    oe_n = 1; #1;
    check("R11 oe high quiets bus", {dq_oe, dq}, 17'h0);
    oe_n = 0; #1;
    check("R11 oe low drives again", {dq_oe, dq}, {1'b1, 16'h5678});
    sleep = 1; #1;
    check("R11 sleep quiets bus", {dq_oe, dq}, 17'h0);
    sleep = 0; #1;

    // R12: sleep holds state across edges
    idle(); sleep = 1; adsc_n = 0; gw_n = 0; addr = 6'h3F; din = 16'h0000; tick();
    check("R12 asleep bus quiet", {dq_oe, dq}, 17'h0);
    tick();
    idle(); #1;
    check("R12 address held over sleep", {dq_oe, dq}, {1'b1, 16'h5678});
    tick();
    check("R12 still held", {dq_oe, dq}, {1'b1, 16'h5678});
    rd(6'h3F);
    check("R12 no write while asleep", {dq_oe, dq}, {1'b1, 16'hABCD});

    done = 1;
    finish_up();
  end
endmodule